// File: doc/BRIEF.md
# FIFO-Buffered Serial Port with 14-Tick Bit Timing

This block is a register-mapped asynchronous serial port that sends and receives 8-bit characters framed as one start bit, eight data bits sent least significant bit first, and one stop bit. There is no parity. A programmable divider turns the system clock into a tick, and every serial bit lasts exactly 14 ticks. Software writes characters into a 64-entry transmit queue and reads them from a 64-entry receive queue through one shared data address.

Each word read from the receive side carries the character and three flags: the queue was empty, the stop bit was bad, and a break was seen. One level register reports how full both queues are. Three interrupt sources are provided: transmit queue running low, receive queue reaching its threshold, and received data left unread for too long. Each source is shown in an identification register, and two enable bits gate them onto one interrupt line.

Top module: `fifo_uart14`

## Requirements
- R1: After reset, txd is 1, irq is 0, and the level (address 1), identification (address 2), control (address 3) and rate (address 4) registers all read 0.
- R2: A write to address 0 puts wdata[7:0] in the transmit queue. The transmitter removes the head entry when it is idle and sends start 0, data bits 0 to 7, then stop 1. Each bit lasts 14 ticks. The character being shifted out is no longer counted in the queue. A write to a full queue is dropped.
- R3: The receiver starts on a falling edge of rxd and rejects the start if the line is high at the middle of the start bit. It samples each bit at the middle of its window and stores the character in bits [7:0] of the receive word.
- R4: A read strobe at address 0 returns the head receive word and removes it. When the receive queue is empty the read returns 0x100 (bit 8 set) and removes nothing.
- R5: A character whose stop bit samples 0 is stored with bit 9 set. If its data bits are also all zero, it is stored with bit 10 set as well.
- R6: Address 1 reads the receive count in bits [7:0] and the transmit count in bits [15:8]. Each queue holds 64 entries. A character received while the receive queue is full is dropped.
- R7: Address 4 holds a rate value N. A tick occurs every N+1 clocks, so a transmitted start bit lasts between 13(N+1)+1 and 14(N+1) clocks.
- R8: Bit 1 of address 2 reads 1 while the receive count is 16 or more.
- R9: Bit 2 of address 2 reads 1 when the receive queue is not empty and no character has been stored or read for 560 ticks (4 ten-bit characters). A store or a read clears it. It never sets while the queue is empty.
- R10: Bit 0 of address 2 is set when the transmit interrupt enable is on and either the enable has just been turned on with a transmit count of 8 or less, or the transmitter takes an entry that leaves 8 or fewer. Writing 1 to bit 0 of address 2 clears it. Writing 0 there has no effect. It never sets while the enable is off.
- R11: In the control register at address 3, bit 6 enables receive interrupts and bit 5 enables transmit interrupts. All other bits read 0. irq is (bit 0 of address 2 and the transmit enable) OR ((bit 1 or bit 2) and the receive enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 3 | Register word address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Read strobe; removes a receive entry when addr is 0 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current addr (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Interrupt request |

## Verification
The main path is tested by sending all 256 byte values with the transmit line looped back to the receive line. A swapped bit order, a stuck data bit or a miscounted length would each corrupt some values, and a separate capture of one asymmetric byte on txd shows which side is wrong. The receiver is also given hand-made frames: a good one, one with a bad stop bit, an all-zero one with a bad stop bit, and a short glitch. These separate the error flag from the break flag and show that a false start is rejected. A sweep of the rate value from 0 to 3 measures the start-bit length in clocks. A fill past 64 entries shows both queue limits and the drop rule.

// File: rtl/uart14_pkg.sv
// Shared constants and types for the 14-tick serial port.
// Assumes a word-addressed register port of three address bits.
package uart14_pkg;
    localparam logic [2:0] A_DATA  = 3'd0;
    localparam logic [2:0] A_LEVEL = 3'd1;
    localparam logic [2:0] A_IIR   = 3'd2;
    localparam logic [2:0] A_CTRL  = 3'd3;
    localparam logic [2:0] A_RATE  = 3'd4;

    localparam int CTRL_TXIE = 5;
    localparam int CTRL_RXIE = 6;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

    // One entry of the receive queue
    typedef struct packed {
        logic       brk;
        logic       err;
        logic [7:0] data;
    } rx_word_t;
endpackage

// File: rtl/uart14_tickgen.sv
// Tick divider: emits a one-clock tick every rate+1 clocks.
// Assumes rate can change at any time; a lowered rate takes effect at once.
module uart14_tickgen #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [RATE_W-1:0] cnt;

    assign tick = (cnt >= rate);

    // Count clocks up to the rate value, then wrap
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (tick)  cnt <= '0;
        else            cnt <= cnt + RATE_W'(1);
    end
endmodule

// File: rtl/uart14_fifo.sv
// Synchronous queue with show-ahead output.
// Assumes DEPTH is a power of two. Push when full and pop when empty are ignored.
module uart14_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          full, do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Storage write; contents need no reset
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + AW'(1);
            if (do_pop)  rp <= rp + AW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart14_tx.sv
// Transmit shifter: takes one queue entry when idle and sends a 10-bit frame.
// Assumes the queue output is valid whenever q_empty is low.
module uart14_tx #(
    parameter int TPB  = 14,
    localparam int TW  = $clog2(TPB)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       q_empty,
    input  logic [7:0] q_data,
    output logic       q_pop,
    output logic       busy,
    output logic       txd
);
    logic [9:0]    frame;
    logic [3:0]    bitn;
    logic [TW-1:0] tcnt;

    assign q_pop = !busy && !q_empty;
    assign txd   = busy ? frame[0] : 1'b1;

    // Load a frame when idle, then advance one bit every TPB ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            frame <= '1;
            bitn  <= '0;
            tcnt  <= '0;
        end else if (q_pop) begin
            busy  <= 1'b1;
            frame <= {1'b1, q_data, 1'b0};
            bitn  <= '0;
            tcnt  <= '0;
        end else if (busy && tick) begin
            if (tcnt == TW'(TPB - 1)) begin
                tcnt  <= '0;
                frame <= {1'b1, frame[9:1]};
                if (bitn == 4'd9) busy <= 1'b0;
                else              bitn <= bitn + 4'd1;
            end else begin
                tcnt <= tcnt + TW'(1);
            end
        end
    end
endmodule

// File: rtl/uart14_rx.sv
// Receive sampler: finds a start edge, samples bits at mid-window, reports one word.
// Assumes rxd is asynchronous; it is synchronised with two flops here.
module uart14_rx
    import uart14_pkg::*;
#(
    parameter int TPB  = 14,
    localparam int TW  = $clog2(TPB),
    localparam int MID = TPB / 2 - 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     rxd,
    output logic     push,
    output rx_word_t word
);
    logic          rx_m, rx_s, rx_p;
    rx_state_e     state;
    logic [TW-1:0] tcnt;
    logic [2:0]    bitn;
    logic [7:0]    sh;

    // Synchronise the line and keep the previous sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_m <= 1'b1;
            rx_s <= 1'b1;
            rx_p <= 1'b1;
        end else begin
            rx_m <= rxd;
            rx_s <= rx_m;
            rx_p <= rx_s;
        end
    end

    // Frame state machine; push pulses for one clock per finished frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            tcnt  <= '0;
            bitn  <= '0;
            sh    <= '0;
            push  <= 1'b0;
            word  <= '0;
        end else begin
            push <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (rx_p && !rx_s) begin
                        state <= RX_START;
                        tcnt  <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (tcnt == TW'(MID) && rx_s) begin
                            state <= RX_IDLE;
                        end else if (tcnt == TW'(TPB - 1)) begin
                            state <= RX_DATA;
                            tcnt  <= '0;
                            bitn  <= '0;
                        end else begin
                            tcnt <= tcnt + TW'(1);
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (tcnt == TW'(MID)) sh <= {rx_s, sh[7:1]};
                        if (tcnt == TW'(TPB - 1)) begin
                            tcnt <= '0;
                            if (bitn == 3'd7) state <= RX_STOP;
                            else              bitn  <= bitn + 3'd1;
                        end else begin
                            tcnt <= tcnt + TW'(1);
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (tcnt == TW'(MID)) begin
                            push      <= 1'b1;
                            word.data <= sh;
                            word.err  <= !rx_s;
                            word.brk  <= !rx_s && (sh == 8'd0);
                            state     <= RX_IDLE;
                        end else begin
                            tcnt <= tcnt + TW'(1);
                        end
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fifo_uart14.sv
// Register-mapped serial port: queues, tick divider, shifters and interrupt logic.
// Assumes DEPTH <= 128 so each count fits its 8-bit field in the level register.
module fifo_uart14
    import uart14_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int TPB      = 14,
    parameter int RATE_W   = 8,
    parameter int RX_TRIG  = 16,
    parameter int TX_TRIG  = 8,
    parameter int TO_CHARS = 4,
    localparam int CW       = $clog2(DEPTH) + 1,
    localparam int TO_LIMIT = TO_CHARS * 10 * TPB,
    localparam int TOW      = $clog2(TO_LIMIT + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  addr,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        rxd,
    output logic        txd,
    output logic        irq
);
    logic [RATE_W-1:0] rate_q;
    logic              rx_ie, tx_ie, tx_ie_d, tx_pend;
    logic              tick;
    logic              tx_pop, tx_empty, tx_busy;
    logic [7:0]        tx_head;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic              rx_push, rx_empty, rx_pop;
    rx_word_t          rx_new, rx_head;
    logic [TOW-1:0]    to_cnt;
    logic              tx_set, tx_clr, rx_trig, rx_to;
    logic              unused_wdata;

    assign unused_wdata = ^wdata[31:8];

    uart14_tickgen #(.RATE_W(RATE_W)) i_tickgen (
        .clk(clk), .rst_n(rst_n), .rate(rate_q), .tick(tick)
    );

    uart14_fifo #(.W(8), .DEPTH(DEPTH)) i_txq (
        .clk(clk), .rst_n(rst_n),
        .push(wr_en && addr == A_DATA), .din(wdata[7:0]),
        .pop(tx_pop), .dout(tx_head), .count(tx_cnt), .empty(tx_empty)
    );

    uart14_tx #(.TPB(TPB)) i_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .q_empty(tx_empty), .q_data(tx_head), .q_pop(tx_pop),
        .busy(tx_busy), .txd(txd)
    );

    uart14_rx #(.TPB(TPB)) i_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .push(rx_push), .word(rx_new)
    );

    assign rx_pop = rd_en && (addr == A_DATA);

    uart14_fifo #(.W($bits(rx_word_t)), .DEPTH(DEPTH)) i_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .din(rx_new),
        .pop(rx_pop), .dout(rx_head), .count(rx_cnt), .empty(rx_empty)
    );

    // Software-visible settings: rate and the two interrupt enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q  <= '0;
            rx_ie   <= 1'b0;
            tx_ie   <= 1'b0;
            tx_ie_d <= 1'b0;
        end else begin
            tx_ie_d <= tx_ie;
            if (wr_en && addr == A_RATE) rate_q <= wdata[RATE_W-1:0];
            if (wr_en && addr == A_CTRL) begin
                rx_ie <= wdata[CTRL_RXIE];
                tx_ie <= wdata[CTRL_TXIE];
            end
        end
    end

    // Transmit-low event: new enable at a low level, or a take that leaves a low level
    assign tx_set = tx_ie && ((!tx_ie_d && tx_cnt <= CW'(TX_TRIG)) ||
                              (tx_pop && tx_cnt <= CW'(TX_TRIG + 1)));
    assign tx_clr = wr_en && (addr == A_IIR) && wdata[0];

    // Sticky transmit interrupt; a new event wins over a clear in the same clock
    always_ff @(posedge clk) begin
        if (!rst_n)      tx_pend <= 1'b0;
        else if (tx_set) tx_pend <= 1'b1;
        else if (tx_clr) tx_pend <= 1'b0;
    end

    // Idle-data timer in ticks, restarted by any store or read of the receive queue
    always_ff @(posedge clk) begin
        if (!rst_n)
            to_cnt <= '0;
        else if (rx_empty || rx_push || rx_pop)
            to_cnt <= '0;
        else if (tick && to_cnt != TOW'(TO_LIMIT))
            to_cnt <= to_cnt + TOW'(1);
    end

    assign rx_trig = (rx_cnt >= CW'(RX_TRIG));
    assign rx_to   = (to_cnt == TOW'(TO_LIMIT)) && !rx_empty;
    assign irq     = (tx_pend && tx_ie) || ((rx_trig || rx_to) && rx_ie);

    // Read multiplexer
    always_comb begin
        rdata = '0;
        case (addr)
            A_DATA: begin
                if (rx_empty) rdata[8] = 1'b1;
                else          rdata[10:0] = {rx_head.brk, rx_head.err, 1'b0, rx_head.data};
            end
            A_LEVEL: rdata[15:0] = {8'(tx_cnt), 8'(rx_cnt)};
            A_IIR:   rdata[2:0]  = {rx_to, rx_trig, tx_pend};
            A_CTRL: begin
                rdata[CTRL_RXIE] = rx_ie;
                rdata[CTRL_TXIE] = tx_ie;
            end
            A_RATE:  rdata[RATE_W-1:0] = rate_q;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart14_checker.sv
// Property checker for the serial port, attached to every instance by bind.
// Assumes it sees the top-level queue counts and interrupt state.
module uart14_checker #(
    parameter int DEPTH   = 64,
    parameter int RX_TRIG = 16,
    parameter int CW      = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    addr,
    input logic          wr_en,
    input logic          rd_en,
    input logic          clr_bit,
    input logic          txd,
    input logic          irq,
    input logic          tx_busy,
    input logic          rx_push,
    input logic [CW-1:0] rx_cnt,
    input logic [CW-1:0] tx_cnt,
    input logic          rx_ie,
    input logic          tx_ie,
    input logic          tx_pend,
    input logic          tx_set
);
    // R2: the last bit of every frame is a high stop bit
    p_stop_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> $past(txd));

    // R6: neither queue ever counts past its depth
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt <= CW'(DEPTH)) && (tx_cnt <= CW'(DEPTH)));

    // R4: a read of an empty receive queue takes nothing
    p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd0 && rx_cnt == '0 && !rx_push) |=> (rx_cnt == '0));

    // R4: a read of a non-empty queue takes exactly one entry
    p_pop_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd0 && rx_cnt != '0 && !rx_push) |=> (rx_cnt == $past(rx_cnt) - CW'(1)));

    // R8: reaching the receive threshold raises irq when enabled
    p_rx_trig_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ie && rx_cnt >= CW'(RX_TRIG)) |-> irq);

    // R10: writing 1 to bit 0 clears the transmit interrupt unless a new event arrives
    p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd2 && clr_bit && !tx_set) |=> !tx_pend);

    // R10: the transmit interrupt cannot set while its enable is off
    p_tx_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ie && !tx_pend) |=> !tx_pend);

    // R11: with both enables off the interrupt line stays low
    p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ie && !tx_ie) |-> !irq);
endmodule

bind fifo_uart14 uart14_checker #(
    .DEPTH(DEPTH), .RX_TRIG(RX_TRIG), .CW(CW)
) i_uart14_checker (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .clr_bit(wdata[0]), .txd(txd), .irq(irq), .tx_busy(tx_busy),
    .rx_push(rx_push), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
    .rx_ie(rx_ie), .tx_ie(tx_ie), .tx_pend(tx_pend), .tx_set(tx_set)
);

// File: tb/test_fifo_uart14.sv
// Self-checking bench for fifo_uart14 at default parameters, rate 0 unless swept.
module test_fifo_uart14;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        loop = 1'b0;
    logic        drv = 1'b1;
    logic        txd, irq;
    logic        rxd;
    int          n_chk = 0;
    int          n_err = 0;

    localparam int BIT = 14;

    assign rxd = loop ? txd : drv;

    always #2 clk = ~clk;

    fifo_uart14 i_fifo_uart14 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_tx_level(input int n);
        logic [31:0] v;
        do rd(3'd1, v); while (int'(v[15:8]) != n);
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop);
        @(negedge clk);
        drv = 1'b0; idle(BIT);
        for (int k = 0; k < 8; k++) begin drv = b[k]; idle(BIT); end
        drv = stop; idle(BIT);
        drv = 1'b1; idle(30);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int lo;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        chk("R1 txd", {31'd0, txd}, 32'd1);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(3'd1, v); chk("R1 level", v, 32'd0);
        rd(3'd2, v); chk("R1 iir", v, 32'd0);
        rd(3'd3, v); chk("R1 ctrl", v, 32'd0);
        rd(3'd4, v); chk("R1 rate", v, 32'd0);

        // R4: empty read returns bit 8 and removes nothing
        rd(3'd0, v); chk("R4 empty read", v, 32'h100);
        rd(3'd1, v); chk("R4 level after empty read", v, 32'd0);

        // R2 R3 R6: all byte values in loopback, batches of 32
        loop = 1'b1;
        for (int b = 0; b < 8; b++) begin
            for (int i = 0; i < 32; i++) wr(3'd0, 32'(b * 32 + i));
            if (b == 0) begin
                rd(3'd1, v); chk("R6 tx count excludes shifting char", v, 32'h1F00);
            end
            idle(33 * 140);
            rd(3'd1, v); chk("R6 rx count after batch", v, 32'h0020);
            for (int i = 0; i < 32; i++) begin
                rd(3'd0, v); chk("R3 loopback byte", v, 32'(b * 32 + i));
            end
        end

        // R2: bit order and levels on txd for 0xB4
        loop = 1'b0;
        idle(20);
        wr(3'd0, 32'hB4);
        while (txd) @(negedge clk);
        idle(7);
        for (int k = 0; k < 10; k++) begin
            logic e;
            e = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : 8'hB4 >> (k - 1);
            chk("R2 frame bit", {31'd0, txd}, {31'd0, e});
            idle(BIT);
        end
        idle(20);

        // R3 R5: hand-driven frames and a glitch
        send_rx(8'hC3, 1'b1);
        send_rx(8'h5A, 1'b0);
        send_rx(8'h00, 1'b0);
        @(negedge clk); drv = 1'b0; idle(3); drv = 1'b1; idle(40);
        rd(3'd1, v); chk("R3 glitch rejected, three words", v, 32'd3);
        rd(3'd0, v); chk("R3 good frame", v, 32'h0C3);
        rd(3'd0, v); chk("R5 bad stop sets error", v, 32'h25A);
        rd(3'd0, v); chk("R5 zero frame sets break", v, 32'h600);
        rd(3'd0, v); chk("R4 empty after drain", v, 32'h100);

        // R8 R9 R10 R11: receive threshold, timeout, enables
        loop = 1'b1;
        wr(3'd3, 32'd0);
        for (int i = 0; i < 15; i++) wr(3'd0, 32'(8'h40 + i));
        idle(16 * 140);
        rd(3'd2, v); chk("R8 below threshold", v, 32'd0);
        wr(3'd0, 32'h4F);
        idle(180);
        rd(3'd2, v); chk("R8 threshold reached", v, 32'd2);
        chk("R11 irq gated off", {31'd0, irq}, 32'd0);
        wr(3'd3, 32'h40);
        chk("R11 irq with rx enable", {31'd0, irq}, 32'd1);
        rd(3'd3, v); chk("R11 ctrl readback", v, 32'h40);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, v); chk("R11 only enable bits kept", v, 32'h60);
        rd(3'd2, v); chk("R10 armed by enable at low level", v, 32'd3);
        wr(3'd2, 32'd0);
        rd(3'd2, v); chk("R10 writing 0 keeps pending", v, 32'd3);
        wr(3'd2, 32'd1);
        rd(3'd2, v); chk("R10 write 1 clears", v, 32'd2);
        wr(3'd3, 32'h40);
        idle(600);
        rd(3'd2, v); chk("R9 timeout pending", v, 32'd6);
        rd(3'd0, v); chk("R9 first entry", v, 32'h40);
        rd(3'd2, v); chk("R9 read clears timeout", v, 32'd0);
        for (int i = 1; i < 16; i++) begin
            rd(3'd0, v); chk("R9 drain entry", v, 32'(8'h40 + i));
        end
        idle(600);
        rd(3'd2, v); chk("R9 no timeout when empty", v, 32'd0);
        chk("R11 irq low when nothing pending", {31'd0, irq}, 32'd0);
        wr(3'd3, 32'd0);

        // R10: transmit low-level interrupt
        loop = 1'b0;
        for (int i = 0; i < 12; i++) wr(3'd0, 32'(i));
        rd(3'd2, v); chk("R10 disabled no pending", v, 32'd0);
        wr(3'd3, 32'h20);
        rd(3'd2, v); chk("R10 enable above level no pending", v, 32'd0);
        chk("R11 irq idle", {31'd0, irq}, 32'd0);
        wait_tx_level(8);
        rd(3'd2, v); chk("R10 set at count 8", v, 32'd1);
        chk("R11 irq from tx", {31'd0, irq}, 32'd1);
        wr(3'd2, 32'd1);
        rd(3'd2, v); chk("R10 cleared", v, 32'd0);
        wait_tx_level(7);
        rd(3'd2, v); chk("R10 set again at count 7", v, 32'd1);
        wr(3'd3, 32'd0);
        wr(3'd2, 32'd1);
        wait_tx_level(0);
        idle(200);
        rd(3'd2, v); chk("R10 no set while disabled", v, 32'd0);

        // R7: rate sweep, start-bit length
        for (int r = 0; r < 4; r++) begin
            wr(3'd4, 32'(r));
            rd(3'd4, v); chk("R7 rate readback", v, 32'(r));
            wr(3'd0, 32'hFF);
            while (txd) @(negedge clk);
            lo = 0;
            while (!txd) begin lo++; @(negedge clk); end
            if (lo >= 13 * (r + 1) + 1 && lo <= 14 * (r + 1))
                chk("R7 start bit length", 32'(lo), 32'(lo));
            else
                chk("R7 start bit length", 32'(lo), 32'(14 * (r + 1)));
            idle(10 * 14 * (r + 1) + 20);
        end
        wr(3'd4, 32'd0);

        // R2 R6: overfill both queues
        loop = 1'b1;
        for (int i = 0; i < 67; i++) wr(3'd0, 32'(i));
        rd(3'd1, v); chk("R2 tx queue saturates", {24'd0, v[15:8]}, 32'd64);
        idle(66 * 140 + 100);
        rd(3'd1, v); chk("R6 rx queue full", v, 32'h0040);
        for (int i = 0; i < 64; i++) begin
            rd(3'd0, v); chk("R6 kept entry", v, 32'(i));
        end
        rd(3'd1, v); chk("R6 extra char dropped", v, 32'd0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule